// File: doc/BRIEF.md
# Internal Interrupt Bus Handshake Controller

This block is the part of a bus controller that hands internal interrupts to the CPU over the shared bus. There are four internal sources. Three are level-4 events: power failing, power coming back, and the periodic software clock tick. The fourth is a level-1 self-interrupt, raised when an operator asks for bus access. The block records each source's rising edge as a pending bit. It picks the most urgent pending source and then runs a fixed handshake for it. First it raises an interrupt notice. It waits for the CPU's select reply and for the bus to be free of other transfers. It then drives a one-cycle acknowledge together with hold, a 2-bit level code and a 3-bit device number. Next it raises strobe and data-valid and waits for the CPU's done. Only after done does it release the bus. A pending bit is cleared only when its handshake completes.

The state machine has six states. IDLE goes to NOTICE when any source is pending. NOTICE goes to ACK when select arrives and no other request is pending, or to WAIT_BUS when select arrives while another request is pending. WAIT_BUS goes to ACK once the other request is gone. ACK always goes to STROBE after one cycle. STROBE goes to RELEASE on done, or back to IDLE on a timeout. RELEASE always goes to IDLE. A front-panel reset request makes the block issue a master reset pulse, which clears every processor function except the CPU. Inside the block, this pulse returns the state machine to IDLE and clears every pending bit.

All bus outputs are active-low and registered. The source requests and the panel reset are asynchronous and pass through two-flop synchronizers. The CPU replies (select, done) and the other-request input are synchronous to `clk`.

Top module: `intirq_bus_ctrl`

## Requirements
- R1: While reset is held, and until the first interrupt, every active-low output is high and `hs_timeout` is low.
- R2: A rising edge on any source request makes `int_notice_n` go low. It stays low until `cpu_select_n` is sampled low, and is high again in the following cycle.
- R3: When several sources are pending, they are served one at a time in this order: power fail, then power restart, then clock tick, then attention. Each level-4 source is therefore served ahead of the level-1 attention.
- R4: In the cycle after select is sampled, `bus_ack_n` and `hold_n` go low, provided `other_req_pending` is low. While `other_req_pending` is high, the acknowledge waits, and it follows in the cycle after that input drops. The acknowledge is low for exactly one cycle.
- R5: While `hold_n` is low, `level_n` carries the inverted level code: 2'b11 for level 4 (so the lines read 00) and 2'b00 for level 1 (so the lines read 11).
- R6: While `hold_n` is low, `data_n` carries the inverted device number: power fail 1, power restart 2, clock tick 3, attention 4.
- R7: In the cycle after the acknowledge, `strobe_n` and `data_valid_n` go low and `bus_ack_n` returns high. Hold, level and device number stay driven.
- R8: In the cycle after `cpu_done_n` is sampled low during the strobe, the strobe, data-valid, hold, level and data lines all return high. The served source is no longer pending: a lone interrupt produces no further notice.
- R9: If done does not arrive, the strobe stays low for exactly 255 cycles. It is then removed, `hs_timeout` is high for that one cycle, and the block returns to idle. The source stays pending and is notified again.
- R10: A rising edge on `panel_reset_req` drives `master_reset_n` low for 4 cycles. It aborts any handshake in progress, so all handshake outputs are high while the master reset is low. It also clears all pending sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_fail_req | input | 1 | Power-fail event (async, edge) |
| pwr_restart_req | input | 1 | Power-restart event (async, edge) |
| clk_tick_req | input | 1 | Software clock tick (async, edge) |
| attn_req | input | 1 | Operator attention request (async, edge) |
| panel_reset_req | input | 1 | Front-panel reset request (async, edge) |
| other_req_pending | input | 1 | Another transfer or interrupt holds off the bus |
| cpu_select_n | input | 1 | CPU select reply to the notice, active low |
| cpu_done_n | input | 1 | CPU done, device number read, active low |
| int_notice_n | output | 1 | Interrupt notice to CPU |
| bus_ack_n | output | 1 | Bus acknowledge, one cycle |
| hold_n | output | 1 | Bus hold |
| level_n | output | 2 | Inverted interrupt level code |
| data_n | output | 3 | Inverted device number on data lines 0 to 2 |
| strobe_n | output | 1 | Bus strobe |
| data_valid_n | output | 1 | Data-valid indication |
| master_reset_n | output | 1 | Master reset to non-CPU functions |
| hs_timeout | output | 1 | One-cycle pulse: done never came |

## Verification
The assertions watch the bus rules on every cycle. These rules are:
- the acknowledge lasts one cycle and only ever starts when no other request was pending;
- strobe never overlaps the acknowledge or the notice;
- strobe always sits under hold;
- the device number is stable during the strobe;
- the level code agrees with the device number;
- every handshake line is released during a master reset.

Only the bench scenarios can show which source wins when several are pending, the exact numbers each source puts on the lines, and that a served source is really forgotten. The same holds for the 255-cycle timeout with its retry, and for the length of the master reset pulse.

// File: rtl/intirq_pkg.sv
package intirq_pkg;

    localparam int NSRC = 4;
    localparam int IW   = $clog2(NSRC);

    // source index order is also the service priority (0 first)
    localparam logic [IW-1:0] SRC_PFAIL = 2'd0;
    localparam logic [IW-1:0] SRC_PRST  = 2'd1;
    localparam logic [IW-1:0] SRC_TICK  = 2'd2;
    localparam logic [IW-1:0] SRC_ATTN  = 2'd3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_NOTICE,
        S_WAIT_BUS,
        S_ACK,
        S_STROBE,
        S_RELEASE
    } hs_state_e;

    function automatic logic [2:0] dev_num(input logic [IW-1:0] idx);
        return 3'(idx) + 3'd1;
    endfunction

    function automatic logic [1:0] lvl_code(input logic [IW-1:0] idx);
        return (idx == SRC_ATTN) ? 2'b00 : 2'b11;
    endfunction

endpackage

// File: rtl/intirq_sync.sv
module intirq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg1_q, stg2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg1_q <= '0;
            stg2_q <= '0;
        end else begin
            stg1_q <= din;
            stg2_q <= stg1_q;
        end
    end

    assign dout = stg2_q;
endmodule

// File: rtl/intirq_pending.sv
module intirq_pending
    import intirq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_sync,
    input  logic          flush,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    output logic          sel_valid,
    output logic [IW-1:0] sel_idx
);
    logic [N-1:0] prev_q, pend_q, rise;

    assign rise = req_sync & ~prev_q;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prev_q[g] <= 1'b0;
                    pend_q[g] <= 1'b0;
                end else begin
                    prev_q[g] <= req_sync[g];
                    if (flush)
                        pend_q[g] <= 1'b0;
                    else if (rise[g])
                        pend_q[g] <= 1'b1;
                    else if (clr_en && clr_idx == IW'(g))
                        pend_q[g] <= 1'b0;
                end
            end
        end
    endgenerate

    // fixed priority: lowest index wins
    always_comb begin
        sel_valid = |pend_q;
        sel_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_q[i]) sel_idx = IW'(i);
        end
    end
endmodule

// File: rtl/intirq_mreset.sv
module intirq_mreset #(
    parameter int MRST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic panel_sync,
    output logic flush,
    output logic master_reset_n
);
    localparam int CW = $clog2(MRST_CYCLES + 1);

    logic          prev_q;
    logic [CW-1:0] cnt_q;
    logic          rise;

    assign rise = panel_sync & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            prev_q <= panel_sync;
            if (rise)
                cnt_q <= CW'(MRST_CYCLES);
            else if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign master_reset_n = (cnt_q == '0);
    assign flush          = rise | (cnt_q != '0);
endmodule

// File: rtl/intirq_seq.sv
module intirq_seq
    import intirq_pkg::*;
#(
    parameter int TMO_CYCLES = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          sel_valid,
    input  logic [IW-1:0] sel_idx,
    input  logic          cpu_select_n,
    input  logic          cpu_done_n,
    input  logic          other_req_pending,
    output logic          clr_en,
    output logic [IW-1:0] clr_idx,
    output logic          int_notice_n,
    output logic          bus_ack_n,
    output logic          hold_n,
    output logic [1:0]    level_n,
    output logic [2:0]    data_n,
    output logic          strobe_n,
    output logic          data_valid_n,
    output logic          hs_timeout
);
    localparam int CW = $clog2(TMO_CYCLES + 1);

    hs_state_e     state_q, state_d;
    logic [IW-1:0] cur_q;
    logic [CW-1:0] wait_q;
    logic          tmo_hit;

    assign tmo_hit = (state_q == S_STROBE) && cpu_done_n && !flush
                     && (wait_q == CW'(TMO_CYCLES - 1));
    assign clr_en  = (state_q == S_STROBE) && !cpu_done_n && !flush;
    assign clr_idx = cur_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (sel_valid) state_d = S_NOTICE;
            S_NOTICE:   if (!cpu_select_n)
                            state_d = other_req_pending ? S_WAIT_BUS : S_ACK;
            S_WAIT_BUS: if (!other_req_pending) state_d = S_ACK;
            S_ACK:      state_d = S_STROBE;
            S_STROBE:   if (!cpu_done_n) state_d = S_RELEASE;
                        else if (tmo_hit) state_d = S_IDLE;
            S_RELEASE:  state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
        if (flush) state_d = S_IDLE;
    end

    // state register, source latch and strobe wait counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
            wait_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && state_d == S_NOTICE)
                cur_q <= sel_idx;
            if (state_d == S_STROBE && state_q != S_STROBE)
                wait_q <= '0;
            else if (state_q == S_STROBE)
                wait_q <= wait_q + 1'b1;
        end
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_notice_n <= 1'b1;
            bus_ack_n    <= 1'b1;
            hold_n       <= 1'b1;
            level_n      <= 2'b11;
            data_n       <= 3'b111;
            strobe_n     <= 1'b1;
            data_valid_n <= 1'b1;
            hs_timeout   <= 1'b0;
        end else begin
            int_notice_n <= 1'b1;
            bus_ack_n    <= 1'b1;
            hold_n       <= 1'b1;
            level_n      <= 2'b11;
            data_n       <= 3'b111;
            strobe_n     <= 1'b1;
            data_valid_n <= 1'b1;
            hs_timeout   <= tmo_hit;
            unique case (state_d)
                S_NOTICE: int_notice_n <= 1'b0;
                S_ACK: begin
                    bus_ack_n <= 1'b0;
                    hold_n    <= 1'b0;
                    level_n   <= ~lvl_code(cur_q);
                    data_n    <= ~dev_num(cur_q);
                end
                S_STROBE: begin
                    hold_n       <= 1'b0;
                    level_n      <= ~lvl_code(cur_q);
                    data_n       <= ~dev_num(cur_q);
                    strobe_n     <= 1'b0;
                    data_valid_n <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/intirq_bus_ctrl.sv
module intirq_bus_ctrl
    import intirq_pkg::*;
#(
    parameter int TMO_CYCLES  = 255,
    parameter int MRST_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_fail_req,
    input  logic       pwr_restart_req,
    input  logic       clk_tick_req,
    input  logic       attn_req,
    input  logic       panel_reset_req,
    input  logic       other_req_pending,
    input  logic       cpu_select_n,
    input  logic       cpu_done_n,
    output logic       int_notice_n,
    output logic       bus_ack_n,
    output logic       hold_n,
    output logic [1:0] level_n,
    output logic [2:0] data_n,
    output logic       strobe_n,
    output logic       data_valid_n,
    output logic       master_reset_n,
    output logic       hs_timeout
);
    localparam int NIN = NSRC + 1;

    logic [NIN-1:0]  async_in, synced;
    logic            flush, sel_valid, clr_en;
    logic [IW-1:0]   sel_idx, clr_idx;

    assign async_in = {panel_reset_req, attn_req, clk_tick_req,
                       pwr_restart_req, pwr_fail_req};

    intirq_sync #(.W(NIN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (async_in),
        .dout (synced)
    );

    intirq_mreset #(.MRST_CYCLES(MRST_CYCLES)) u_mrst (
        .clk           (clk),
        .rst_n         (rst_n),
        .panel_sync    (synced[NSRC]),
        .flush         (flush),
        .master_reset_n(master_reset_n)
    );

    intirq_pending #(.N(NSRC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_sync (synced[NSRC-1:0]),
        .flush    (flush),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx),
        .sel_valid(sel_valid),
        .sel_idx  (sel_idx)
    );

    intirq_seq #(.TMO_CYCLES(TMO_CYCLES)) u_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .flush            (flush),
        .sel_valid        (sel_valid),
        .sel_idx          (sel_idx),
        .cpu_select_n     (cpu_select_n),
        .cpu_done_n       (cpu_done_n),
        .other_req_pending(other_req_pending),
        .clr_en           (clr_en),
        .clr_idx          (clr_idx),
        .int_notice_n     (int_notice_n),
        .bus_ack_n        (bus_ack_n),
        .hold_n           (hold_n),
        .level_n          (level_n),
        .data_n           (data_n),
        .strobe_n         (strobe_n),
        .data_valid_n     (data_valid_n),
        .hs_timeout       (hs_timeout)
    );
endmodule

// File: rtl/intirq_chk.sv
module intirq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       other_req_pending,
    input logic       int_notice_n,
    input logic       bus_ack_n,
    input logic       hold_n,
    input logic [1:0] level_n,
    input logic [2:0] data_n,
    input logic       strobe_n,
    input logic       master_reset_n,
    input logic       hs_timeout
);
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack_n |=> bus_ack_n);                                         // R4
    AST_ACK_NEEDS_FREE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ack_n) |-> !$past(other_req_pending));                   // R4
    AST_ACK_THEN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack_n |=> (!strobe_n || !master_reset_n));                    // R7
    AST_STROBE_NOT_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |-> (bus_ack_n && int_notice_n && !hold_n));             // R7
    AST_DEV_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n && $past(!strobe_n)) |-> $stable(data_n));              // R6
    AST_LEVEL_MATCHES_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_n |-> ((data_n == 3'b011) == (level_n == 2'b11)));           // R5
    AST_TIMEOUT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        hs_timeout |-> (strobe_n && hold_n && $past(!strobe_n)));          // R9
    AST_MRESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !master_reset_n |-> (strobe_n && hold_n && int_notice_n && bus_ack_n)); // R10
endmodule

bind intirq_bus_ctrl intirq_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .other_req_pending(other_req_pending),
    .int_notice_n     (int_notice_n),
    .bus_ack_n        (bus_ack_n),
    .hold_n           (hold_n),
    .level_n          (level_n),
    .data_n           (data_n),
    .strobe_n         (strobe_n),
    .master_reset_n   (master_reset_n),
    .hs_timeout       (hs_timeout)
);

// File: tb/intirq_bus_ctrl_tb.sv
`timescale 1ns/1ps
module intirq_bus_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_fail_req = 1'b0, pwr_restart_req = 1'b0;
    logic       clk_tick_req = 1'b0, attn_req = 1'b0, panel_reset_req = 1'b0;
    logic       other_req_pending = 1'b0, cpu_select_n = 1'b1, cpu_done_n = 1'b1;
    logic       int_notice_n, bus_ack_n, hold_n, strobe_n, data_valid_n;
    logic       master_reset_n, hs_timeout;
    logic [1:0] level_n;
    logic [2:0] data_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    intirq_bus_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .pwr_fail_req(pwr_fail_req), .pwr_restart_req(pwr_restart_req),
        .clk_tick_req(clk_tick_req), .attn_req(attn_req),
        .panel_reset_req(panel_reset_req), .other_req_pending(other_req_pending),
        .cpu_select_n(cpu_select_n), .cpu_done_n(cpu_done_n),
        .int_notice_n(int_notice_n), .bus_ack_n(bus_ack_n), .hold_n(hold_n),
        .level_n(level_n), .data_n(data_n), .strobe_n(strobe_n),
        .data_valid_n(data_valid_n), .master_reset_n(master_reset_n),
        .hs_timeout(hs_timeout)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("[TB] FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk) sig = 1'b1;
        repeat (3) @(negedge clk);
        sig = 1'b0;
    endtask

    // wait at negedges for the notice; reports R2 if it never comes
    task automatic wait_notice();
        int n = 0;
        while (int_notice_n && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(int_notice_n == 1'b0, "R2 notice", int_notice_n, 0);
    endtask

    // one complete handshake, checking every step
    task automatic serve(input int dev, input int lvl, input int busy, input string tag);
        wait_notice();
        if (busy > 0) other_req_pending = 1'b1;
        cpu_select_n = 1'b0;
        @(negedge clk);
        cpu_select_n = 1'b1;
        chk(int_notice_n == 1'b1, "R2 notice drop", int_notice_n, 1);
        if (busy > 0) begin
            repeat (busy) begin
                chk(bus_ack_n == 1'b1 && strobe_n == 1'b1, "R4 ack held off", bus_ack_n, 1);
                @(negedge clk);
            end
            other_req_pending = 1'b0;
            @(negedge clk);
        end
        chk(bus_ack_n == 1'b0 && hold_n == 1'b0, "R4 ack+hold", {bus_ack_n, hold_n}, 0);
        chk(level_n == 2'(~lvl), {"R5 level ", tag}, level_n, 2'(~lvl));
        chk(data_n == 3'(~dev), {"R6 device ", tag}, data_n, 3'(~dev));
        @(negedge clk);
        chk(strobe_n == 1'b0 && data_valid_n == 1'b0 && bus_ack_n == 1'b1 && hold_n == 1'b0,
            "R7 strobe phase", {strobe_n, data_valid_n, bus_ack_n, hold_n}, 4'b0010);
        chk(data_n == 3'(~dev), {"R7 device held ", tag}, data_n, 3'(~dev));
        cpu_done_n = 1'b0;
        @(negedge clk);
        cpu_done_n = 1'b1;
        chk(strobe_n && data_valid_n && hold_n && level_n == 2'b11 && data_n == 3'b111,
            "R8 release", {strobe_n, data_valid_n, hold_n, level_n, data_n}, 8'hFF);
    endtask

    task automatic expect_quiet(input int cycles, input string req);
        int lows = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (!int_notice_n) lows++;
        end
        chk(lows == 0, req, lows, 0);
    endtask

    task automatic t_reset();
        chk(int_notice_n && bus_ack_n && hold_n && strobe_n && data_valid_n &&
            master_reset_n && level_n == 2'b11 && data_n == 3'b111 && !hs_timeout,
            "R1 reset state", {int_notice_n, bus_ack_n, hold_n, strobe_n}, 4'hF);
    endtask

    task automatic t_singles();
        pulse(pwr_fail_req);    serve(1, 3, 0, "pfail");   expect_quiet(10, "R8 pfail cleared");
        pulse(pwr_restart_req); serve(2, 3, 0, "prst");    expect_quiet(10, "R8 prst cleared");
        pulse(clk_tick_req);    serve(3, 3, 0, "tick");    expect_quiet(10, "R8 tick cleared");
        pulse(attn_req);        serve(4, 0, 0, "attn");    expect_quiet(10, "R8 attn cleared");
    endtask

    task automatic t_priority();
        @(negedge clk);
        attn_req = 1'b1; clk_tick_req = 1'b1; pwr_fail_req = 1'b1; pwr_restart_req = 1'b1;
        repeat (3) @(negedge clk);
        attn_req = 1'b0; clk_tick_req = 1'b0; pwr_fail_req = 1'b0; pwr_restart_req = 1'b0;
        serve(1, 3, 0, "R3 first pfail");
        serve(2, 3, 0, "R3 second prst");
        serve(3, 3, 0, "R3 third tick");
        serve(4, 0, 0, "R3 last attn");
        expect_quiet(10, "R3 all served");
    endtask

    task automatic t_busy();
        pulse(clk_tick_req);
        serve(3, 3, 5, "R4 busy tick");
        expect_quiet(5, "R8 busy cleared");
    endtask

    task automatic t_timeout();
        int n = 0;
        pulse(pwr_restart_req);
        wait_notice();
        cpu_select_n = 1'b0;
        @(negedge clk);
        cpu_select_n = 1'b1;
        @(negedge clk);
        while (!strobe_n && n < 400) begin
            n++;
            @(negedge clk);
        end
        chk(n == 255, "R9 strobe length", n, 255);
        chk(hs_timeout == 1'b1 && strobe_n && hold_n, "R9 timeout flag", hs_timeout, 1);
        @(negedge clk);
        chk(hs_timeout == 1'b0, "R9 flag one cycle", hs_timeout, 0);
        serve(2, 3, 0, "R9 retry prst");
        expect_quiet(5, "R9 retry cleared");
    endtask

    task automatic t_mreset();
        int n = 0;
        int w = 0;
        pulse(pwr_fail_req);
        wait_notice();
        cpu_select_n = 1'b0;
        @(negedge clk);
        cpu_select_n = 1'b1;
        @(negedge clk);
        chk(strobe_n == 1'b0, "R10 strobe before reset", strobe_n, 0);
        pulse(pwr_restart_req);
        panel_reset_req = 1'b1;
        while (master_reset_n && w < 20) begin
            @(negedge clk);
            w++;
        end
        chk(strobe_n && hold_n && int_notice_n, "R10 abort", {strobe_n, hold_n, int_notice_n}, 7);
        while (!master_reset_n && n < 20) begin
            n++;
            @(negedge clk);
        end
        panel_reset_req = 1'b0;
        chk(n == 4, "R10 pulse length", n, 4);
        expect_quiet(20, "R10 pending cleared");
    endtask

    initial begin
        fork
            begin
                repeat (5) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_singles();
                t_priority();
                t_busy();
                t_timeout();
                t_mreset();
            end
            begin
                repeat (100000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("[TB] FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule